// File: doc/BRIEF.md
# Shadow Stack Return Verifier

This unit sits between an execute stage and one data memory port and turns call and return commands into checked stack traffic. For a user-mode call it moves the stack pointer down by one slot. It then writes the return address twice: first into the ordinary stack slot and then into a mirrored slot. The mirrored slot's address is the ordinary one with a single fixed address bit inverted. For a user-mode return it reads both copies and compares them. It releases the target and pops the slot only when the two copies agree. Otherwise it reports a fault and hands back both values for diagnosis.

In supervisor mode a call or a return touches the ordinary slot only and performs no comparison. A separate combinational path checks ordinary user loads and stores. It flags any of them whose address falls in the mirrored region, meaning the inverted bit is set. The execute stage presents one command at a time through a valid/ready pair and waits for a one-cycle completion pulse.

Top module: `shadow_ret_guard`

## Requirements
- R1: The mirrored slot address equals the ordinary slot address with bit SHADOW_BIT (default 40) inverted; all other bits are identical.
- R2: A user call (cmd_ret=0, cmd_user=1) at stack pointer S issues exactly two writes of cmd_ret_addr, to S-8 first and to its mirror second. It completes with done_sp = S-8, done_fault = 0 and done_target = 0.
- R3: A user return (cmd_ret=1, cmd_user=1) at S issues exactly two reads, from S first and from its mirror second. When the values match, it completes with done_fault = 0, done_target = the value read and done_sp = S+8.
- R4: When the two copies read by a user return differ, the return completes with done_fault = 1 and done_sp = S (unchanged). flt_normal carries the ordinary copy and flt_shadow carries the mirrored copy.
- R5: In supervisor mode (cmd_user=0), a call issues one write to S-8 only, and a return issues one read from S only, with no fault and done_sp = S+8.
- R6: ls_fault is high in the same cycle exactly when ls_valid, ls_user and bit SHADOW_BIT of ls_addr are all 1.
- R7: cmd_ready is high only when the unit is idle, and busy is its inverse. A command held on cmd_valid while the unit is busy is not accepted until the running operation has completed.
- R8: mem_req, once raised, stays high with stable mem_addr and mem_wdata until mem_rsp. mem_we is 1 for call accesses and 0 for return accesses.
- R9: After reset, cmd_ready = 1, busy = 0, mem_req = 0 and done_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command taken this cycle if valid |
| cmd_ret | input | 1 | 1 = return, 0 = call |
| cmd_user | input | 1 | 1 = user mode, 0 = supervisor |
| cmd_sp | input | 64 | Stack pointer before the operation |
| cmd_ret_addr | input | 64 | Return address to push (call only) |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data |
| mem_rsp | input | 1 | Access complete (one-cycle pulse) |
| mem_rdata | input | 64 | Read data, valid with mem_rsp |
| done_valid | output | 1 | Operation finished (one-cycle pulse) |
| done_fault | output | 1 | Return copies disagreed |
| done_target | output | 64 | Released return target (0 for calls) |
| done_sp | output | 64 | Stack pointer after the operation |
| flt_normal | output | 64 | Ordinary copy read by the return |
| flt_shadow | output | 64 | Mirrored copy read by the return |
| ls_valid | input | 1 | Ordinary load/store present |
| ls_user | input | 1 | Load/store issued in user mode |
| ls_addr | input | 64 | Load/store address |
| ls_fault | output | 1 | Load/store targets the mirrored region |

## Verification
The assertions assume that the memory raises mem_rsp only while mem_req is high, and for one cycle per access. They also assume that stack pointers given with commands lie outside the mirrored region. The bench's memory model answers every request exactly once after a chosen latency from zero to three cycles. All stack pointers it generates keep bit 40 clear. Mismatching copies are produced only by overwriting the mirrored slot in the model between a call and its return. The bench never forges responses.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC0 = 2'd1,
        ST_ACC1 = 2'd2,
        ST_FIN  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/ssv_addr_map.sv
module ssv_addr_map #(
    parameter int ADDR_W     = 64,
    parameter int SHADOW_BIT = 40
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] shadow_o
);
    localparam logic [ADDR_W-1:0] FLIP_MASK = ADDR_W'(1) << SHADOW_BIT;

    assign shadow_o = addr_i ^ FLIP_MASK;
endmodule

// File: rtl/ssv_ls_filter.sv
module ssv_ls_filter #(
    parameter int ADDR_W     = 64,
    parameter int SHADOW_BIT = 40
) (
    input  logic              ls_valid_i,
    input  logic              ls_user_i,
    input  logic [ADDR_W-1:0] ls_addr_i,
    output logic              ls_fault_o
);
    assign ls_fault_o = ls_valid_i & ls_user_i & ls_addr_i[SHADOW_BIT];
endmodule

// File: rtl/ssv_seq.sv
module ssv_seq
    import ssv_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int DATA_W     = 64,
    parameter int SLOT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic              cmd_ret_i,
    input  logic              cmd_user_i,
    input  logic [ADDR_W-1:0] cmd_sp_i,
    input  logic [DATA_W-1:0] cmd_ret_addr_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] slot_o,
    input  logic [ADDR_W-1:0] shadow_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_rsp_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              done_valid_o,
    output logic              done_fault_o,
    output logic [DATA_W-1:0] done_target_o,
    output logic [ADDR_W-1:0] done_sp_o,
    output logic [DATA_W-1:0] flt_normal_o,
    output logic [DATA_W-1:0] flt_shadow_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SLOT_BYTES);

    typedef struct packed {
        seq_st_e           st;
        logic              is_ret;
        logic              user;
        logic [ADDR_W-1:0] slot;
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] rd0;
        logic [DATA_W-1:0] rd1;
        logic              miss;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    r_d.st     = ST_ACC0;
                    r_d.is_ret = cmd_ret_i;
                    r_d.user   = cmd_user_i;
                    r_d.slot   = cmd_ret_i ? cmd_sp_i : cmd_sp_i - STEP;
                    r_d.val    = cmd_ret_addr_i;
                    r_d.rd0    = '0;
                    r_d.rd1    = '0;
                    r_d.miss   = 1'b0;
                end
            end
            ST_ACC0: begin
                if (mem_rsp_i) begin
                    r_d.rd0 = mem_rdata_i;
                    r_d.st  = r_q.user ? ST_ACC1 : ST_FIN;
                end
            end
            ST_ACC1: begin
                if (mem_rsp_i) begin
                    r_d.rd1  = mem_rdata_i;
                    r_d.miss = r_q.is_ret && (r_q.rd0 != mem_rdata_i);
                    r_d.st   = ST_FIN;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready_o   = (r_q.st == ST_IDLE);
    assign busy_o        = (r_q.st != ST_IDLE);
    assign slot_o        = r_q.slot;
    assign mem_req_o     = (r_q.st == ST_ACC0) || (r_q.st == ST_ACC1);
    assign mem_we_o      = !r_q.is_ret;
    assign mem_addr_o    = (r_q.st == ST_ACC1) ? shadow_i : r_q.slot;
    assign mem_wdata_o   = r_q.val;
    assign done_valid_o  = (r_q.st == ST_FIN);
    assign done_fault_o  = r_q.miss;
    assign done_target_o = r_q.is_ret ? r_q.rd0 : '0;
    assign done_sp_o     = (r_q.is_ret && !r_q.miss) ? r_q.slot + STEP : r_q.slot;
    assign flt_normal_o  = r_q.rd0;
    assign flt_shadow_o  = r_q.rd1;

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rsp_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    assert_fault_user_ret_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid_o && done_fault_o) |-> (r_q.is_ret && r_q.user));

    assert_fault_keeps_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid_o && done_fault_o) |-> (done_sp_o == cmd_sp_hold));

    assert_super_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !r_q.user) |-> (r_q.st == ST_ACC0));

    assert_accept_only_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cmd_valid_i));

    // Stack pointer captured at acceptance, kept for the fault check only.
    logic [ADDR_W-1:0] cmd_sp_hold;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_sp_hold <= '0;
        end else if (cmd_valid_i && cmd_ready_o) begin
            cmd_sp_hold <= cmd_sp_i;
        end
    end
endmodule

// File: rtl/shadow_ret_guard.sv
module shadow_ret_guard #(
    parameter int ADDR_W     = 64,
    parameter int DATA_W     = 64,
    parameter int SLOT_BYTES = 8,
    parameter int SHADOW_BIT = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_ret,
    input  logic              cmd_user,
    input  logic [ADDR_W-1:0] cmd_sp,
    input  logic [DATA_W-1:0] cmd_ret_addr,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done_valid,
    output logic              done_fault,
    output logic [DATA_W-1:0] done_target,
    output logic [ADDR_W-1:0] done_sp,
    output logic [DATA_W-1:0] flt_normal,
    output logic [DATA_W-1:0] flt_shadow,
    input  logic              ls_valid,
    input  logic              ls_user,
    input  logic [ADDR_W-1:0] ls_addr,
    output logic              ls_fault
);
    logic [ADDR_W-1:0] slot_w;
    logic [ADDR_W-1:0] shadow_w;

    ssv_addr_map #(.ADDR_W(ADDR_W), .SHADOW_BIT(SHADOW_BIT)) u_map (
        .addr_i   (slot_w),
        .shadow_o (shadow_w)
    );

    ssv_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid_i    (cmd_valid),
        .cmd_ready_o    (cmd_ready),
        .cmd_ret_i      (cmd_ret),
        .cmd_user_i     (cmd_user),
        .cmd_sp_i       (cmd_sp),
        .cmd_ret_addr_i (cmd_ret_addr),
        .busy_o         (busy),
        .slot_o         (slot_w),
        .shadow_i       (shadow_w),
        .mem_req_o      (mem_req),
        .mem_we_o       (mem_we),
        .mem_addr_o     (mem_addr),
        .mem_wdata_o    (mem_wdata),
        .mem_rsp_i      (mem_rsp),
        .mem_rdata_i    (mem_rdata),
        .done_valid_o   (done_valid),
        .done_fault_o   (done_fault),
        .done_target_o  (done_target),
        .done_sp_o      (done_sp),
        .flt_normal_o   (flt_normal),
        .flt_shadow_o   (flt_shadow)
    );

    ssv_ls_filter #(.ADDR_W(ADDR_W), .SHADOW_BIT(SHADOW_BIT)) u_ls (
        .ls_valid_i (ls_valid),
        .ls_user_i  (ls_user),
        .ls_addr_i  (ls_addr),
        .ls_fault_o (ls_fault)
    );

    assert_mirror_one_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && busy) |-> ($countones(slot_w ^ shadow_w) == 1));
endmodule

// File: tb/tb_shadow_ret_guard.sv
module tb_shadow_ret_guard;
    localparam logic [63:0] MASK = 64'h1 << 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ret = 1'b0, cmd_user = 1'b0;
    logic [63:0] cmd_sp = '0, cmd_ret_addr = '0;
    logic        cmd_ready, busy, mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic        mem_rsp = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done_valid, done_fault, ls_fault;
    logic [63:0] done_target, done_sp, flt_normal, flt_shadow;
    logic        ls_valid = 1'b0, ls_user = 1'b0;
    logic [63:0] ls_addr = '0;

    shadow_ret_guard dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_ret(cmd_ret), .cmd_user(cmd_user), .cmd_sp(cmd_sp), .cmd_ret_addr(cmd_ret_addr),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rsp(mem_rsp), .mem_rdata(mem_rdata),
        .done_valid(done_valid), .done_fault(done_fault), .done_target(done_target),
        .done_sp(done_sp), .flt_normal(flt_normal), .flt_shadow(flt_shadow),
        .ls_valid(ls_valid), .ls_user(ls_user), .ls_addr(ls_addr), .ls_fault(ls_fault)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    int lat = 0, cnt = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] log_addr [8];
    logic        log_we [8];
    logic [63:0] log_wd [8];
    int          log_n = 0;
    int          viol_r7 = 0, viol_r8 = 0;
    bit          finished = 0;

    // Memory model: one response per request, after lat idle cycles.
    always @(posedge clk) begin
        if (mem_rsp) begin
            mem_rsp <= 1'b0;
            cnt <= 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                mem_rsp   <= 1'b1;
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
                if (mem_we) mem[mem_addr] = mem_wdata;
                if (log_n < 8) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                    log_wd[log_n]   = mem_wdata;
                end
                log_n = log_n + 1;
                cnt <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    // Protocol monitors for R7 and R8.
    logic        p_req = 0, p_rsp = 0;
    logic [63:0] p_addr = 0, p_wd = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy == cmd_ready) viol_r7++;
            if (p_req && !p_rsp && !(mem_req && mem_addr == p_addr && mem_wdata == p_wd)) viol_r8++;
        end
        p_req = mem_req; p_rsp = mem_rsp; p_addr = mem_addr; p_wd = mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input bit ret, input bit user, input logic [63:0] sp, input logic [63:0] ra);
        int guard;
        @(negedge clk);
        log_n = 0;
        cmd_ret = ret; cmd_user = user; cmd_sp = sp; cmd_ret_addr = ra; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        guard = 0;
        while (!done_valid && guard < 100) begin @(negedge clk); guard++; end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++; fails++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                summary();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(cmd_ready && !busy && !mem_req && !done_valid, "R9 reset",
            {cmd_ready, busy, mem_req, done_valid}, 4'b1000);

        for (int l = 0; l < 4; l++) begin
            lat = l;
            for (int u = 0; u < 2; u++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [63:0] s, ra, slot;
                    s    = 64'h1000_0000 + 64'(k) * 64'h100 + 64'(l) * 64'h1000;
                    ra   = 64'hA000_0000 + 64'(l * 16 + u * 4 + k);
                    slot = s - 64'd8;
                    run_cmd(1'b0, u[0], s, ra);
                    if (u == 1) begin
                        // R2 user call: two writes, ordinary then mirror (R1)
                        chk(log_n == 2, "R2 call access count", 64'(log_n), 64'd2);
                        chk(log_addr[0] == slot && log_we[0] && log_wd[0] == ra, "R2 first write", log_addr[0], slot);
                        chk(log_addr[1] == (slot ^ MASK) && log_we[1] && log_wd[1] == ra, "R1 mirror write", log_addr[1], slot ^ MASK);
                    end else begin
                        // R5 supervisor call: single write
                        chk(log_n == 1 && log_addr[0] == slot && log_we[0], "R5 super call", 64'(log_n), 64'd1);
                    end
                    chk(done_sp == slot && !done_fault && done_target == 0, "R2 call result", done_sp, slot);

                    run_cmd(1'b1, u[0], slot, 64'h0);
                    if (u == 1) begin
                        chk(log_n == 2 && !log_we[0] && !log_we[1] && log_addr[0] == slot && log_addr[1] == (slot ^ MASK),
                            "R3 return reads", log_addr[1], slot ^ MASK);
                    end else begin
                        chk(log_n == 1 && !log_we[0] && log_addr[0] == slot, "R5 super return", 64'(log_n), 64'd1);
                    end
                    chk(!done_fault && done_target == ra && done_sp == s, "R3 return result", done_target, ra);

                    if (u == 1) begin
                        // R4 mismatch: corrupt the mirror copy
                        run_cmd(1'b0, 1'b1, s, ra);
                        mem[slot ^ MASK] = ra ^ (64'h1 << k);
                        run_cmd(1'b1, 1'b1, slot, 64'h0);
                        chk(done_fault && done_sp == slot, "R4 fault sp", done_sp, slot);
                        chk(flt_normal == ra && flt_shadow == (ra ^ (64'h1 << k)), "R4 fault values", flt_shadow, ra ^ (64'h1 << k));
                    end else begin
                        // R5 supervisor return ignores a corrupted mirror
                        run_cmd(1'b0, 1'b0, s, ra);
                        mem[slot ^ MASK] = ~ra;
                        run_cmd(1'b1, 1'b0, slot, 64'h0);
                        chk(!done_fault && done_target == ra && done_sp == s, "R5 no compare", done_target, ra);
                    end
                end
            end
        end

        // R7: command held during busy is taken only once per operation
        lat = 2;
        @(negedge clk);
        log_n = 0;
        cmd_ret = 1'b0; cmd_user = 1'b1; cmd_sp = 64'h2000_0000; cmd_ret_addr = 64'h55; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_sp = 64'h3000_0000;
        chk(!cmd_ready && busy, "R7 busy blocks", {63'h0, cmd_ready}, 64'h0);
        while (!done_valid) @(negedge clk);
        chk(log_n == 2 && log_addr[0] == 64'h1FFF_FFF8, "R7 single accept", 64'(log_n), 64'd2);
        cmd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!busy, "R7 dropped command not taken", {63'h0, busy}, 64'h0);

        // R6 load/store filter sweep
        for (int m = 0; m < 16; m++) begin
            bit v, uu, b, o;
            v = m[0]; uu = m[1]; b = m[2]; o = m[3];
            ls_valid = v; ls_user = uu;
            ls_addr = 64'h1234_5678 | (b ? MASK : 64'h0) | (o ? (64'h1 << 39) : 64'h0) | (o ? (64'h1 << 41) : 64'h0);
            #1;
            chk(ls_fault == (v & uu & b), "R6 ls_fault", {63'h0, ls_fault}, {63'h0, v & uu & b});
        end
        ls_valid = 1'b0;

        chk(viol_r7 == 0, "R7 ready/busy monitor", 64'(viol_r7), 64'd0);
        chk(viol_r8 == 0, "R8 request hold monitor", 64'(viol_r8), 64'd0);
        finished = 1;
        summary();
    end
endmodule